// File: doc/BRIEF.md
# Fractional-Increment Precision Time Counter

This block keeps a free-running nanosecond time base. On every clock tick it adds a programmable increment to a wide accumulator. The increment is a fixed-point number: its low 19 bits are fractions of a nanosecond and its upper 5 bits are whole nanoseconds. Software can therefore trim the counter's rate in very small steps, without ever stopping it or stepping it.

The accumulator is 64 bits wide: 45 bits of whole nanoseconds sit above the 19 fraction bits. Software sees it through a 32-bit strobe-based register port as two words. Two ordering rules keep a two-word access coherent. A read of the low word freezes a copy of the whole accumulator, and the high word is then served from that copy. A write to the low word is parked in a staging register, and the accumulator is replaced in a single cycle only when the high word is written.

Top module: `tc_time_counter`

## Requirements
- R1: While and after reset, the accumulator is zero and the increment holds the nominal 16 ns step, which is 0x0080_0000 (16 shifted left by 19).
- R2: On each clock edge without a time load, the 64-bit accumulator becomes its previous value plus the zero-extended 24-bit increment. Register address 0 (low word) maps to accumulator bits 31:0, including the 19 fraction bits in 18:0. Address 1 (high word) maps to bits 63:32.
- R3: A read strobe to address 0 returns accumulator bits 31:0 as they stood before that edge, on `rd_data` one cycle later. The same edge captures all 64 bits into a snapshot.
- R4: A read strobe to address 1 returns bits 63:32 of the snapshot one cycle later, not the live accumulator.
- R5: Each new read of address 0 replaces the snapshot, even if the previous snapshot's high word was never read.
- R6: A write strobe to address 0 only stages the word. The accumulator keeps counting undisturbed.
- R7: A write strobe to address 1 loads the accumulator with the written word in bits 63:32, bits 31:19 of the staged word below it, and zeros in fraction bits 18:0. The accumulator does not advance on that edge.
- R8: A write strobe to address 2 loads bits 23:0 of the write data as the new increment. The accumulator still adds the old increment on that edge, and the new increment is used from the next edge on.
- R9: A read strobe to address 2 returns the increment, zero-extended to 32 bits, one cycle later.
- R10: The accumulator wraps silently modulo 2^64. Both the high and low words roll to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter and register clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| addr | input | 2 | Register select: 0 low word, 1 high word, 2 increment, 3 unused (reads zero) |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data, valid the cycle after `rd_en` |

## Verification
The checker assumes that one strobe addresses one register at a time. It also assumes that a read and a write are not issued to the same address in the same cycle. Its invariants are written relative to the previous edge, and they only start once one full cycle has passed since reset, so the prior-cycle values they compare against are always defined. The stimulus issues exactly one access per cycle. Each access starts on a falling edge and is released on the next one, so every expected value can be derived by counting rising edges from the most recent time load.

// File: rtl/tc_pkg.sv
package tc_pkg;
  typedef enum logic [1:0] {
    SEL_TIME_LO = 2'd0,
    SEL_TIME_HI = 2'd1,
    SEL_STEP    = 2'd2,
    SEL_SPARE   = 2'd3
  } tc_sel_e;

  localparam int unsigned TC_DATA_W  = 32;
  localparam int unsigned TC_FRAC_W  = 19;
  localparam int unsigned TC_STEP_W  = 24;
  localparam int unsigned TC_NS_W    = 45;
  localparam int unsigned TC_NOM_NS  = 16;
endpackage

// File: rtl/tc_step_reg.sv
module tc_step_reg #(
  parameter int unsigned STEP_W = 24,
  parameter int unsigned FRAC_W = 19,
  parameter int unsigned NOM_NS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [STEP_W-1:0] load_val,
  output logic [STEP_W-1:0] step
);
  localparam logic [STEP_W-1:0] NOMINAL = STEP_W'(NOM_NS) << FRAC_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      step <= NOMINAL;
    end else if (load) begin
      step <= load_val;
    end
  end
endmodule

// File: rtl/tc_accum.sv
module tc_accum #(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned STEP_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STEP_W-1:0] step,
  input  logic              load,
  input  logic [CNT_W-1:0]  load_val,
  output logic [CNT_W-1:0]  count
);
  logic [CNT_W-1:0] next_count;

  // zero-extended step; wrap modulo 2^CNT_W is the natural carry-out drop
  assign next_count = count + CNT_W'(step);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (load) begin
      count <= load_val;
    end else begin
      count <= next_count;
    end
  end
endmodule

// File: rtl/tc_host_port.sv
module tc_host_port
  import tc_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned STEP_W = 24,
  parameter int unsigned FRAC_W = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CNT_W-1:0]  count,
  input  logic [STEP_W-1:0] step,
  output logic              time_load,
  output logic [CNT_W-1:0]  time_val,
  output logic              step_load,
  output logic [STEP_W-1:0] step_val,
  output logic [CNT_W-1:0]  snap,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned HI_W    = CNT_W - DATA_W;
  localparam int unsigned LO_NS_W = DATA_W - FRAC_W;

  tc_sel_e sel;
  logic [DATA_W-1:0] stage_lo;
  logic [DATA_W-1:0] rd_next;

  assign sel = tc_sel_e'(addr);

  assign time_load = wr_en && (sel == SEL_TIME_HI);
  assign step_load = wr_en && (sel == SEL_STEP);
  assign step_val  = wr_data[STEP_W-1:0];
  assign time_val  = {wr_data[HI_W-1:0], stage_lo[DATA_W-1 -: LO_NS_W], {FRAC_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_lo <= '0;
    end else if (wr_en && (sel == SEL_TIME_LO)) begin
      stage_lo <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snap <= '0;
    end else if (rd_en && (sel == SEL_TIME_LO)) begin
      snap <= count;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_TIME_LO: rd_next = count[DATA_W-1:0];
      SEL_TIME_HI: rd_next = DATA_W'(snap[CNT_W-1:DATA_W]);
      SEL_STEP:    rd_next = DATA_W'(step);
      default:     rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= rd_next;
    end
  end
endmodule

// File: rtl/tc_time_counter.sv
module tc_time_counter
  import tc_pkg::*;
#(
  parameter int unsigned DATA_W = TC_DATA_W,
  parameter int unsigned FRAC_W = TC_FRAC_W,
  parameter int unsigned STEP_W = TC_STEP_W,
  parameter int unsigned NS_W   = TC_NS_W,
  parameter int unsigned NOM_NS = TC_NOM_NS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned CNT_W = NS_W + FRAC_W;

  logic [CNT_W-1:0]  cnt_w;
  logic [CNT_W-1:0]  snap_w;
  logic [CNT_W-1:0]  time_val;
  logic [STEP_W-1:0] step_w;
  logic [STEP_W-1:0] step_val;
  logic              time_load;
  logic              step_load;

  tc_step_reg #(
    .STEP_W (STEP_W),
    .FRAC_W (FRAC_W),
    .NOM_NS (NOM_NS)
  ) u_step (
    .clk      (clk),
    .rst      (rst),
    .load     (step_load),
    .load_val (step_val),
    .step     (step_w)
  );

  tc_accum #(
    .CNT_W  (CNT_W),
    .STEP_W (STEP_W)
  ) u_accum (
    .clk      (clk),
    .rst      (rst),
    .step     (step_w),
    .load     (time_load),
    .load_val (time_val),
    .count    (cnt_w)
  );

  tc_host_port #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .STEP_W (STEP_W),
    .FRAC_W (FRAC_W)
  ) u_port (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wr_data   (wr_data),
    .count     (cnt_w),
    .step      (step_w),
    .time_load (time_load),
    .time_val  (time_val),
    .step_load (step_load),
    .step_val  (step_val),
    .snap      (snap_w),
    .rd_data   (rd_data)
  );
endmodule

// File: rtl/tc_time_counter_chk.sv
module tc_time_counter_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned STEP_W = 24,
  parameter int unsigned FRAC_W = 19,
  parameter int unsigned NOM_NS = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [1:0]        addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic [CNT_W-1:0]  cnt_w,
  input logic [CNT_W-1:0]  snap_w,
  input logic [STEP_W-1:0] step_w
);
  localparam logic [STEP_W-1:0] NOMINAL = STEP_W'(NOM_NS) << FRAC_W;

  logic seen;
  always_ff @(posedge clk) begin
    if (rst) seen <= 1'b0;
    else     seen <= 1'b1;
  end

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (cnt_w == '0 && step_w == NOMINAL)); // R1

  AST_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    seen && !$past(wr_en && addr == 2'd1)
      |-> cnt_w == $past(cnt_w) + CNT_W'($past(step_w))); // R2

  AST_SNAP_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    seen && $past(rd_en && addr == 2'd0) |-> snap_w == $past(cnt_w)); // R3

  AST_HI_FROM_SNAP: assert property (@(posedge clk) disable iff (rst)
    seen && $past(rd_en && addr == 2'd1)
      |-> rd_data == DATA_W'($past(snap_w[CNT_W-1:DATA_W]))); // R4

  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    seen && !$past(rd_en && addr == 2'd0) |-> $stable(snap_w)); // R5

  AST_LOAD_FRAC_CLEAR: assert property (@(posedge clk) disable iff (rst)
    seen && $past(wr_en && addr == 2'd1)
      |-> (cnt_w[FRAC_W-1:0] == '0 && cnt_w[CNT_W-1:DATA_W] == $past(wr_data))); // R7

  AST_STEP_HOLD: assert property (@(posedge clk) disable iff (rst)
    seen && !$past(wr_en && addr == 2'd2) |-> $stable(step_w)); // R8
endmodule

bind tc_time_counter tc_time_counter_chk #(
  .DATA_W (DATA_W),
  .CNT_W  (CNT_W),
  .STEP_W (STEP_W),
  .FRAC_W (FRAC_W),
  .NOM_NS (NOM_NS)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .addr    (addr),
  .wr_data (wr_data),
  .rd_data (rd_data),
  .cnt_w   (cnt_w),
  .snap_w  (snap_w),
  .step_w  (step_w)
);

// File: tb/tc_time_counter_bench.sv
`timescale 1ns/1ps
module tc_time_counter_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  tc_time_counter u_tc_time_counter (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wr_data (wr_data),
    .rd_data (rd_data)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  // each access occupies exactly one rising edge; called on a falling edge
  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    reg_rd(2'd0, v); check("R1 low word after reset", v, 32'h0);
    reg_rd(2'd1, v); check("R1 high word after reset", v, 32'h0);
    reg_rd(2'd2, v); check("R1 R9 nominal step", v, 32'h0080_0000);
  endtask

  task automatic t_load();
    logic [31:0] v;
    reg_wr(2'd0, 32'h1234_5678);
    reg_wr(2'd1, 32'h0000_00AB);
    reg_rd(2'd0, v); check("R7 fraction cleared on load", v, 32'h1230_0000);
    reg_rd(2'd1, v); check("R7 high word loaded", v, 32'h0000_00AB);
    reg_rd(2'd0, v); check("R2 two ticks of nominal step", v, 32'h1330_0000);
  endtask

  task automatic t_snapshot();
    logic [31:0] v;
    reg_wr(2'd0, 32'hFFF8_0000);
    reg_wr(2'd1, 32'h0000_0005);
    reg_rd(2'd0, v); check("R3 low word captured", v, 32'hFFF8_0000);
    repeat (3) @(negedge clk);
    reg_rd(2'd1, v); check("R4 high word from snapshot not live", v, 32'h0000_0005);
    reg_rd(2'd0, v); check("R2 carry into high word", v, 32'h0278_0000);
    reg_rd(2'd1, v); check("R5 snapshot refreshed", v, 32'h0000_0006);
  endtask

  task automatic t_staging();
    logic [31:0] v;
    reg_wr(2'd0, 32'h0);
    reg_wr(2'd1, 32'h0);
    reg_wr(2'd0, 32'hDEAD_0000);
    reg_rd(2'd0, v); check("R6 staged low write leaves counter", v, 32'h0080_0000);
    reg_wr(2'd1, 32'h0000_0077);
    reg_rd(2'd0, v); check("R6 R7 staged low word committed", v, 32'hDEA8_0000);
    reg_rd(2'd1, v); check("R7 high word committed", v, 32'h0000_0077);
  endtask

  task automatic t_step();
    logic [31:0] v;
    reg_wr(2'd0, 32'h0);
    reg_wr(2'd1, 32'h0);
    reg_wr(2'd2, 32'h0008_0001);
    reg_rd(2'd0, v); check("R8 old step on load edge", v, 32'h0080_0000);
    reg_rd(2'd0, v); check("R8 new fractional step applied", v, 32'h0088_0001);
    reg_rd(2'd2, v); check("R9 step readback", v, 32'h0008_0001);
    reg_wr(2'd2, 32'hFF08_0001);
    reg_rd(2'd2, v); check("R9 step upper bits dropped", v, 32'h0008_0001);
    reg_wr(2'd2, 32'h0080_0000);
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    reg_wr(2'd0, 32'hFFF8_0000);
    reg_wr(2'd1, 32'hFFFF_FFFF);
    reg_rd(2'd0, v); check("R10 at full scale", v, 32'hFFF8_0000);
    reg_rd(2'd0, v); check("R10 low word after wrap", v, 32'h0078_0000);
    reg_rd(2'd1, v); check("R10 R5 high word after wrap", v, 32'h0000_0000);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_load();
    t_snapshot();
    t_staging();
    t_step();
    t_wrap();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule